// File: doc/BRIEF.md
# Iterative Integer Multiply/Divide Unit

This unit sits next to the execute stage. It takes two operands and a two-bit operation code, then works for a fixed number of cycles to form a 64-bit product or a quotient and remainder. The main pipeline keeps issuing independent instructions during that time. Results go into a private pair of registers, HI and LO, so the unit never needs a write port on the main register file.

Multiplication uses a shift-and-add loop with one step per operand bit. Division uses a restoring loop with the same number of steps. One more cycle then fixes up the signs. A later move-from instruction reads HI or LO through a select input. If it tries to read while the unit is busy, the unit raises a stall request. A new start that arrives while the unit is busy is refused the same way.

Top module: `muldiv_unit`

## Requirements
- R1: After reset, `busy` and `stallReq` are low, and `hiOut` and `loOut` are zero.
- R2: A `startReq` that arrives while idle is taken on that clock edge. `busy` is high from the next cycle for exactly WIDTH+1 cycles (33 at the default width). The results are valid in the first cycle in which `busy` is low again.
- R3: `opSel` selects the operation: 2'b00 is unsigned multiply and 2'b01 is signed multiply. For both, HI gets the upper half and LO the lower half of the full 64-bit product.
- R4: `opSel` 2'b10 is unsigned divide. LO gets the quotient and HI gets the remainder.
- R5: `opSel` 2'b11 is signed divide. The quotient is truncated toward zero and the remainder has the sign of the dividend. The most negative value divided by -1 gives LO = 0x80000000 and HI = 0.
- R6: A divide whose divisor is zero takes the normal time. It gives LO = all ones and HI = the dividend, for both signed and unsigned divide.
- R7: While `busy` is high, `hiOut` and `loOut` keep their previous values. They change only when an operation completes.
- R8: `rdData` shows HI when `rdSel` is 1 and LO when `rdSel` is 0.
- R9: `stallReq` is high whenever `rdReq` is high while `busy` is high. When `busy` is low, `stallReq` is low.
- R10: A `startReq` that arrives while `busy` is high raises `stallReq` and has no effect. The running operation finishes with its own result and no extra operation follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startReq | input | 1 | Begin an operation |
| opSel | input | 2 | Operation code (see R3 to R5) |
| srcA | input | 32 | Multiplicand or dividend |
| srcB | input | 32 | Multiplier or divisor |
| rdReq | input | 1 | A move-from instruction wants HI or LO |
| rdSel | input | 1 | 1 selects HI, 0 selects LO |
| busy | output | 1 | Operation in progress |
| stallReq | output | 1 | Hold the issuing pipeline stage |
| hiOut | output | 32 | HI result register |
| loOut | output | 32 | LO result register |
| rdData | output | 32 | Selected result register |

## Verification
A bad iteration counter shows up as a `busy` pulse of the wrong length. The bench sees that on the first operation, within about 34 cycles of the start. A corrupted accumulator or a wrong sign flag gives wrong HI or LO values in the cycle after completion. The operand mix, which covers negative values, the most negative value, large unsigned values and a zero divisor, catches such errors in the first operation that uses the affected path. A leak through the start interlock shows up as a changed result or as a second `busy` pulse that no request matches.

// File: rtl/muldiv_pkg.sv
package muldiv_pkg;
  // opSel encoding: bit 1 selects divide, bit 0 selects signed
  typedef enum logic [1:0] {
    OP_MULU = 2'b00,
    OP_MULS = 2'b01,
    OP_DIVU = 2'b10,
    OP_DIVS = 2'b11
  } mdOp_e;

  // strobes from control to datapath
  typedef struct packed {
    logic load;    // capture operands and seed the accumulator
    logic step;    // one shift-add or restoring-subtract iteration
    logic finish;  // sign fix-up and write HI/LO
  } mdCtl_t;
endpackage

// File: rtl/muldiv_ctrl.sv
module muldiv_ctrl
  import muldiv_pkg::*;
#(
  parameter int ITERS = 32
) (
  input  logic   clk,
  input  logic   rstN,
  input  logic   startReq,
  output mdCtl_t ctl,
  output logic   busy
);
  localparam int CW = $clog2(ITERS + 1);

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_FIX} state_e;
  state_e        state;
  logic [CW-1:0] iterCnt;

  assign busy = (state != S_IDLE);

  always_comb begin
    ctl        = '0;
    ctl.load   = (state == S_IDLE) && startReq;
    ctl.step   = (state == S_RUN);
    ctl.finish = (state == S_FIX);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= S_IDLE;
      iterCnt <= '0;
    end else begin
      case (state)
        S_IDLE: if (startReq) begin
          state   <= S_RUN;
          iterCnt <= '0;
        end
        S_RUN: begin
          iterCnt <= iterCnt + 1'b1;
          if (iterCnt == CW'(ITERS - 1)) state <= S_FIX;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // checker: count busy cycles
  logic [CW:0] busyCnt;
  always_ff @(posedge clk) begin
    if (!rstN || !busy) busyCnt <= '0;
    else                busyCnt <= busyCnt + 1'b1;
  end

  assert_start_busy_R2: assert property (@(posedge clk) disable iff (!rstN)
    (startReq && !busy) |=> busy);

  assert_busy_len_R2: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> (busyCnt == (CW+1)'(ITERS + 1)));
endmodule

// File: rtl/muldiv_dpath.sv
module muldiv_dpath
  import muldiv_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  mdCtl_t           ctl,
  input  logic [1:0]       opSel,
  input  logic [WIDTH-1:0] srcA,
  input  logic [WIDTH-1:0] srcB,
  output logic [WIDTH-1:0] hiOut,
  output logic [WIDTH-1:0] loOut
);
  logic [1:0]       opR;
  logic [WIDTH-1:0] origA, magB, accHi, accLo, hiR, loR;
  logic             negA, negB;

  // load-time magnitudes
  logic             sgnA, sgnB;
  logic [WIDTH-1:0] magAIn, magBIn;
  assign sgnA   = opSel[0] & srcA[WIDTH-1];
  assign sgnB   = opSel[0] & srcB[WIDTH-1];
  assign magAIn = sgnA ? -srcA : srcA;
  assign magBIn = sgnB ? -srcB : srcB;

  // one multiply step
  logic [WIDTH:0] mulSum;
  assign mulSum = {1'b0, accHi} + (accLo[0] ? {1'b0, magB} : '0);

  // one restoring divide step
  logic [WIDTH:0]   divTrial;
  logic [WIDTH-1:0] divDiff;
  logic             divOk;
  assign divTrial = {accHi, accLo[WIDTH-1]};
  assign divOk    = (divTrial >= {1'b0, magB});
  assign divDiff  = divTrial[WIDTH-1:0] - magB;

  // completion values
  logic [2*WIDTH-1:0] prodFix;
  logic [WIDTH-1:0]   quoFix, remFix;
  assign prodFix = (negA ^ negB) ? -{accHi, accLo} : {accHi, accLo};
  assign quoFix  = (negA ^ negB) ? -accLo : accLo;
  assign remFix  = negA ? -accHi : accHi;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      opR <= '0; origA <= '0; magB <= '0; negA <= 1'b0; negB <= 1'b0;
      accHi <= '0; accLo <= '0; hiR <= '0; loR <= '0;
    end else begin
      if (ctl.load) begin
        opR   <= opSel;
        origA <= srcA;
        magB  <= magBIn;
        negA  <= sgnA;
        negB  <= sgnB;
        accHi <= '0;
        accLo <= magAIn;
      end
      if (ctl.step) begin
        if (!opR[1]) begin
          accHi <= mulSum[WIDTH:1];
          accLo <= {mulSum[0], accLo[WIDTH-1:1]};
        end else begin
          accHi <= divOk ? divDiff : divTrial[WIDTH-1:0];
          accLo <= {accLo[WIDTH-2:0], divOk};
        end
      end
      if (ctl.finish) begin
        if (!opR[1]) begin
          hiR <= prodFix[2*WIDTH-1:WIDTH];
          loR <= prodFix[WIDTH-1:0];
        end else if (magB == '0) begin
          hiR <= origA;
          loR <= '1;
        end else begin
          hiR <= remFix;
          loR <= quoFix;
        end
      end
    end
  end

  assign hiOut = hiR;
  assign loOut = loR;

  assert_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.finish |=> ($stable(hiR) && $stable(loR)));

  assert_divzero_R6: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.finish && opR[1] && magB == '0) |=> (loR == '1 && hiR == $past(origA)));

  assert_opnd_stable_R10: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.load |=> ($stable(opR) && $stable(origA) && $stable(magB)));
endmodule

// File: rtl/muldiv_unit.sv
module muldiv_unit
  import muldiv_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startReq,
  input  logic [1:0]       opSel,
  input  logic [WIDTH-1:0] srcA,
  input  logic [WIDTH-1:0] srcB,
  input  logic             rdReq,
  input  logic             rdSel,
  output logic             busy,
  output logic             stallReq,
  output logic [WIDTH-1:0] hiOut,
  output logic [WIDTH-1:0] loOut,
  output logic [WIDTH-1:0] rdData
);
  mdCtl_t ctl;

  muldiv_ctrl #(.ITERS(WIDTH)) uCtrl (
    .clk(clk), .rstN(rstN), .startReq(startReq), .ctl(ctl), .busy(busy)
  );

  muldiv_dpath #(.WIDTH(WIDTH)) uDpath (
    .clk(clk), .rstN(rstN), .ctl(ctl), .opSel(opSel),
    .srcA(srcA), .srcB(srcB), .hiOut(hiOut), .loOut(loOut)
  );

  // interlock: reads and new starts wait for the running operation
  assign stallReq = busy & (rdReq | startReq);
  assign rdData   = rdSel ? hiOut : loOut;
endmodule

// File: tb/sim_muldiv_unit.sv
module sim_muldiv_unit;
  localparam int W = 32;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          startReq = 1'b0;
  logic [1:0]    opSel = '0;
  logic [W-1:0]  srcA = '0, srcB = '0;
  logic          rdReq = 1'b0, rdSel = 1'b0;
  logic          busy, stallReq;
  logic [W-1:0]  hiOut, loOut, rdData;

  always #10 clk = ~clk;  // 50 MHz

  muldiv_unit u0 (
    .clk(clk), .rstN(rstN), .startReq(startReq), .opSel(opSel),
    .srcA(srcA), .srcB(srcB), .rdReq(rdReq), .rdSel(rdSel),
    .busy(busy), .stallReq(stallReq), .hiOut(hiOut), .loOut(loOut), .rdData(rdData)
  );

  typedef struct { logic [W-1:0] hi; logic [W-1:0] lo; string tag; } exp_t;
  exp_t expQ[$];

  int checks = 0, errors = 0, doneOps = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic exp_t model(input logic [1:0] op, input logic [W-1:0] a, input logic [W-1:0] b);
    exp_t e;
    longint p, q, r;
    case (op)
      2'b00: begin p = longint'({32'b0, a}) * longint'({32'b0, b}); e.tag = "R3 mulu"; end
      2'b01: begin p = longint'($signed(a)) * longint'($signed(b)); e.tag = "R3 muls"; end
      2'b10: begin
        if (b == 0) begin q = -1; r = longint'(a); e.tag = "R6 divu/0"; end
        else begin q = longint'(a / b); r = longint'(a % b); e.tag = "R4 divu"; end
        p = {r[31:0], q[31:0]};
      end
      default: begin
        if (b == 0) begin q = -1; r = longint'(a); e.tag = "R6 divs/0"; end
        else begin
          q = longint'($signed(a)) / longint'($signed(b));
          r = longint'($signed(a)) % longint'($signed(b));
          e.tag = "R5 divs";
        end
        p = {r[31:0], q[31:0]};
      end
    endcase
    e.hi = p[63:32];
    e.lo = p[31:0];
    return e;
  endfunction

  // driver: waits for idle, issues one start and pushes the expected result
  task automatic runOp(input logic [1:0] op, input logic [W-1:0] a, input logic [W-1:0] b);
    @(negedge clk);
    while (busy) @(negedge clk);
    startReq = 1'b1; opSel = op; srcA = a; srcB = b;
    expQ.push_back(model(op, a, b));
    @(negedge clk);
    startReq = 1'b0;
    chk(busy === 1'b1, "R2 busy after start", {63'b0, busy}, 64'd1);
  endtask

  task automatic waitIdle();
    while (busy) @(negedge clk);
  endtask

  // monitor: pop and compare on each completion
  bit prevBusy = 1'b0;
  int busyLen = 0;
  always @(negedge clk) begin
    if (rstN) begin
      if (busy) busyLen++;
      if (prevBusy && !busy) begin
        doneOps++;
        chk(busyLen == W + 1, "R2 busy length", 64'(busyLen), 64'(W + 1));
        if (expQ.size() == 0) begin
          chk(1'b0, "R10 unexpected completion", {hiOut, loOut}, 64'd0);
        end else begin
          exp_t e;
          e = expQ.pop_front();
          chk({hiOut, loOut} === {e.hi, e.lo}, e.tag, {hiOut, loOut}, {e.hi, e.lo});
        end
        busyLen = 0;
      end
      prevBusy = busy;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(busy === 1'b0 && stallReq === 1'b0, "R1 reset busy/stall", {62'b0, busy, stallReq}, 64'd0);
    chk({hiOut, loOut} === 64'd0, "R1 reset HI/LO", {hiOut, loOut}, 64'd0);
    rstN = 1'b1;

    runOp(2'b00, 32'd7, 32'd9);
    runOp(2'b00, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    runOp(2'b01, 32'hFFFF_FFFD, 32'd5);
    runOp(2'b01, 32'h8000_0000, 32'h8000_0000);
    runOp(2'b10, 32'd100, 32'd7);
    runOp(2'b10, 32'hFFFF_FFFF, 32'd16);
    runOp(2'b11, -32'sd7, 32'd2);
    runOp(2'b11, 32'd7, -32'sd2);
    runOp(2'b11, 32'h8000_0000, 32'hFFFF_FFFF);
    runOp(2'b10, 32'h1234_5678, 32'd0);
    runOp(2'b11, -32'sd100, 32'd0);
    waitIdle();
    @(negedge clk);

    // R8: read select
    rdSel = 1'b0; #1;
    chk(rdData === loOut, "R8 rdData LO", {32'b0, rdData}, {32'b0, loOut});
    rdSel = 1'b1; #1;
    chk(rdData === hiOut, "R8 rdData HI", {32'b0, rdData}, {32'b0, hiOut});
    rdReq = 1'b1; #1;
    chk(stallReq === 1'b0, "R9 no stall when idle", {63'b0, stallReq}, 64'd0);
    rdReq = 1'b0;

    // R7, R9, R10: activity while busy
    begin
      logic [W-1:0] oldHi, oldLo;
      oldHi = hiOut; oldLo = loOut;
      runOp(2'b00, 32'd3, 32'd4);
      repeat (5) @(negedge clk);
      chk({hiOut, loOut} === {oldHi, oldLo}, "R7 HI/LO hold while busy", {hiOut, loOut}, {oldHi, oldLo});
      rdReq = 1'b1; #1;
      chk(stallReq === 1'b1, "R9 stall on read while busy", {63'b0, stallReq}, 64'd1);
      rdReq = 1'b0;
      startReq = 1'b1; opSel = 2'b10; srcA = 32'd99; srcB = 32'd3; #1;
      chk(stallReq === 1'b1, "R10 stall on start while busy", {63'b0, stallReq}, 64'd1);
      @(negedge clk);
      startReq = 1'b0;
      srcA = '0; srcB = '0;
      waitIdle();
      repeat (4) @(negedge clk);
      chk(busy === 1'b0, "R10 ignored start leaves unit idle", {63'b0, busy}, 64'd0);
    end

    chk(doneOps == 12, "R2 completion count", 64'(doneOps), 64'd12);
    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule